// File: doc/BRIEF.md
# GPIO Port Pin Control Register Bank

This block runs a parameterised general-purpose I/O port of `PIN_W` pins, eight by default. A simple register bus reads and writes five per-pin configuration registers: output value, direction, pull enable, pull polarity and open-drain mode. From these the block computes, for every pin, the pad control signals:

- the level to drive;
- the output enable;
- a pull-up request;
- a pull-down request.

The pad cell and the pull resistors sit outside the block. Here they appear as plain logic outputs.

A pin set as an output can be driven push-pull. It can also be driven as an open-drain pin, which only pulls low and lets the line float high through an external resistor. A pin set as an input may request a pull device, and the polarity bit chooses which one. A read of the value register returns a mix: the stored output value for output pins, and the synchronised pad level for input pins. The pad level passes through a `SYNC_STAGES`-deep flop chain.

Top module: `gpio_pin_ctl`

## Requirements
- R1: After reset every register is zero. As a result pad_oe, pad_pu, pad_pd and bus_rdata are all zero, and every pin is an undriven input with no pull.
- R2: A write (bus_sel=1, bus_wr=1) updates the addressed register at the clock edge. A read (bus_sel=1, bus_wr=0) puts the register value on bus_rdata one cycle later, and bus_rdata holds that value until the next read. The register offsets are:
  - value 0x0
  - direction 0x1 (1 = output)
  - pull enable 0xC
  - pull polarity 0xD
  - open-drain mode 0xE
- R3: A read of offset 0x0 returns, for each pin with direction 0, the level seen on pin_in SYNC_STAGES clock edges before the read edge.
- R4: pad_pu[i] is 1 exactly when direction[i]=0, pull enable[i]=1 and polarity[i]=0. pad_pd[i] is 1 exactly when direction[i]=0, pull enable[i]=1 and polarity[i]=1.
- R5: pad_pu[i] and pad_pd[i] are never both 1.
- R6: With direction[i]=1 and open-drain[i]=0, pad_oe[i]=1 and pad_out[i] equals value[i].
- R7: With direction[i]=1 and open-drain[i]=1:
  - if value[i]=0, pad_oe[i]=1 and pad_out[i]=0;
  - if value[i]=1, pad_oe[i]=0.
- R8: With direction[i]=0, pad_oe[i]=0 whatever the open-drain bit is.
- R9: A read of any offset other than the five above returns zero. A write to such an offset changes no register.
- R10: A value written while a pin is an input is kept. When the pin later becomes an output, that value is driven and is returned by reads of offset 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Registered read data |
| pin_in | input | PIN_W | Asynchronous pad input levels |
| pad_out | output | PIN_W | Level to drive on each pad |
| pad_oe | output | PIN_W | Per-pad output enable |
| pad_pu | output | PIN_W | Per-pad pull-up request |
| pad_pd | output | PIN_W | Per-pad pull-down request |

## Verification
The bench builds the block with its defaults: PIN_W=8, ADDR_W=4 and SYNC_STAGES=2. A four-bit offset space has only sixteen addresses, so the directed phase can sweep every unmapped offset for reads and writes. The random phase also lands on unmapped offsets often. Eight pins let one written pattern mix inputs and outputs, push-pull and open-drain pins, and pull-up and pull-down pins, so all the per-pin rules are compared side by side in the same cycle. With a two-stage chain, the bench model can keep the synchronised input level as a short queue, and each input change reaches a read after exactly two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [2:0] {
      REG_VAL  = 3'd0,
      REG_DIR  = 3'd1,
      REG_PEN  = 3'd2,
      REG_POL  = 3'd3,
      REG_OD   = 3'd4
   } gpio_reg_e;

   localparam int unsigned GPIO_NREG = 5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pkg::*;
#(
   parameter int unsigned PIN_W   = 8,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned OFF_VAL = 0,
   parameter int unsigned OFF_DIR = 1,
   parameter int unsigned OFF_PEN = 12,
   parameter int unsigned OFF_POL = 13,
   parameter int unsigned OFF_OD  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PIN_W-1:0]  wdata,
   input  logic [PIN_W-1:0]  pin_sync,
   output logic [PIN_W-1:0]  val_r,
   output logic [PIN_W-1:0]  dir_r,
   output logic [PIN_W-1:0]  pen_r,
   output logic [PIN_W-1:0]  pol_r,
   output logic [PIN_W-1:0]  od_r,
   output logic [PIN_W-1:0]  rdata
);
   localparam logic [ADDR_W-1:0] OFFS [GPIO_NREG] = '{
      ADDR_W'(OFF_VAL), ADDR_W'(OFF_DIR), ADDR_W'(OFF_PEN),
      ADDR_W'(OFF_POL), ADDR_W'(OFF_OD)
   };

   logic [PIN_W-1:0] cfg_q [GPIO_NREG];
   logic [GPIO_NREG-1:0] hit;
   logic [PIN_W-1:0] val_view;
   logic [PIN_W-1:0] rd_nxt;

   for (genvar k = 0; k < GPIO_NREG; k++) begin : g_reg
      assign hit[k] = (addr == OFFS[k]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   cfg_q[k] <= '0;
         else if (sel && wr && hit[k]) cfg_q[k] <= wdata;
      end
   end

   assign val_r = cfg_q[REG_VAL];
   assign dir_r = cfg_q[REG_DIR];
   assign pen_r = cfg_q[REG_PEN];
   assign pol_r = cfg_q[REG_POL];
   assign od_r  = cfg_q[REG_OD];

   assign val_view = (dir_r & val_r) | (~dir_r & pin_sync);

   always_comb begin
      rd_nxt = '0;
      for (int k = 0; k < GPIO_NREG; k++) begin
         if (hit[k]) rd_nxt = (k == int'(REG_VAL)) ? val_view : cfg_q[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata <= '0;
      else if (sel && !wr) rdata <= rd_nxt;
   end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int unsigned PIN_W = 8
) (
   input  logic [PIN_W-1:0] val_r,
   input  logic [PIN_W-1:0] dir_r,
   input  logic [PIN_W-1:0] pen_r,
   input  logic [PIN_W-1:0] pol_r,
   input  logic [PIN_W-1:0] od_r,
   output logic [PIN_W-1:0] pad_out,
   output logic [PIN_W-1:0] pad_oe,
   output logic [PIN_W-1:0] pad_pu,
   output logic [PIN_W-1:0] pad_pd
);
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      logic pull_on;
      assign pull_on    = !dir_r[i] && pen_r[i];
      assign pad_out[i] = val_r[i];
      assign pad_oe[i]  = dir_r[i] && (!od_r[i] || !val_r[i]);
      assign pad_pu[i]  = pull_on && !pol_r[i];
      assign pad_pd[i]  = pull_on && pol_r[i];
   end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFF_VAL     = 0,
   parameter int unsigned OFF_DIR     = 1,
   parameter int unsigned OFF_PEN     = 12,
   parameter int unsigned OFF_POL     = 13,
   parameter int unsigned OFF_OD      = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PIN_W-1:0]  bus_wdata,
   output logic [PIN_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pad_out,
   output logic [PIN_W-1:0]  pad_oe,
   output logic [PIN_W-1:0]  pad_pu,
   output logic [PIN_W-1:0]  pad_pd
);
   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   if (PIN_W < 1) begin : g_bad_width
      $error("gpio_pin_ctl: PIN_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pin_ctl: SYNC_STAGES must be at least 2");
   end
   if (OFF_VAL >= ADDR_SPAN || OFF_DIR >= ADDR_SPAN || OFF_PEN >= ADDR_SPAN ||
       OFF_POL >= ADDR_SPAN || OFF_OD >= ADDR_SPAN) begin : g_bad_off
      $error("gpio_pin_ctl: register offset outside ADDR_W space");
   end
   if (OFF_VAL == OFF_DIR || OFF_VAL == OFF_PEN || OFF_VAL == OFF_POL ||
       OFF_VAL == OFF_OD  || OFF_DIR == OFF_PEN || OFF_DIR == OFF_POL ||
       OFF_DIR == OFF_OD  || OFF_PEN == OFF_POL || OFF_PEN == OFF_OD  ||
       OFF_POL == OFF_OD) begin : g_dup_off
      $error("gpio_pin_ctl: register offsets must be distinct");
   end

   logic [PIN_W-1:0] pin_sync;
   logic [PIN_W-1:0] val_r, dir_r, pen_r, pol_r, od_r;

   gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .d_sync  (pin_sync)
   );

   gpio_regfile #(
      .PIN_W(PIN_W), .ADDR_W(ADDR_W), .OFF_VAL(OFF_VAL), .OFF_DIR(OFF_DIR),
      .OFF_PEN(OFF_PEN), .OFF_POL(OFF_POL), .OFF_OD(OFF_OD)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bus_sel),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync),
      .val_r    (val_r),
      .dir_r    (dir_r),
      .pen_r    (pen_r),
      .pol_r    (pol_r),
      .od_r     (od_r),
      .rdata    (bus_rdata)
   );

   gpio_pad_ctl #(.PIN_W(PIN_W)) u_pads (
      .val_r   (val_r),
      .dir_r   (dir_r),
      .pen_r   (pen_r),
      .pol_r   (pol_r),
      .od_r    (od_r),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .pad_pu  (pad_pu),
      .pad_pd  (pad_pd)
   );
endmodule

// File: rtl/gpio_pin_ctl_chk.sv
module gpio_pin_ctl_chk #(
   parameter int unsigned PIN_W   = 8,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned OFF_VAL = 0,
   parameter int unsigned OFF_DIR = 1,
   parameter int unsigned OFF_PEN = 12,
   parameter int unsigned OFF_POL = 13,
   parameter int unsigned OFF_OD  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [PIN_W-1:0]  bus_wdata,
   input logic [PIN_W-1:0]  val_r,
   input logic [PIN_W-1:0]  dir_r,
   input logic [PIN_W-1:0]  pen_r,
   input logic [PIN_W-1:0]  pol_r,
   input logic [PIN_W-1:0]  od_r,
   input logic [PIN_W-1:0]  pad_oe,
   input logic [PIN_W-1:0]  pad_pu,
   input logic [PIN_W-1:0]  pad_pd
);
   logic unmapped;
   assign unmapped = (bus_addr != ADDR_W'(OFF_VAL)) && (bus_addr != ADDR_W'(OFF_DIR)) &&
                     (bus_addr != ADDR_W'(OFF_PEN)) && (bus_addr != ADDR_W'(OFF_POL)) &&
                     (bus_addr != ADDR_W'(OFF_OD));

   // R5
   pull_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_pd) == '0);

   // R4
   pull_only_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu | pad_pd) & (dir_r | ~pen_r)) == '0);

   // R8
   input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_r) == '0);

   // R7
   od_high_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & od_r & val_r) == '0);

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DIR)) |=> (dir_r == $past(bus_wdata)));

   // R9
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && unmapped) |=>
         ($stable(val_r) && $stable(dir_r) && $stable(pen_r) && $stable(pol_r) && $stable(od_r)));
endmodule

bind gpio_pin_ctl gpio_pin_ctl_chk #(
   .PIN_W(PIN_W), .ADDR_W(ADDR_W), .OFF_VAL(OFF_VAL), .OFF_DIR(OFF_DIR),
   .OFF_PEN(OFF_PEN), .OFF_POL(OFF_POL), .OFF_OD(OFF_OD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .val_r     (val_r),
   .dir_r     (dir_r),
   .pen_r     (pen_r),
   .pol_r     (pol_r),
   .od_r      (od_r),
   .pad_oe    (pad_oe),
   .pad_pu    (pad_pu),
   .pad_pd    (pad_pd)
);

// File: tb/gpio_pin_ctl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctl_tb;
   localparam int W  = 8;
   localparam int AW = 4;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  pad_out, pad_oe, pad_pu, pad_pd;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_pin_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pu(pad_pu), .pad_pd(pad_pd)
   );

   // behavioural reference
   logic [W-1:0] m_val, m_dir, m_pen, m_pol, m_od, m_rd;
   logic [W-1:0] sync_q [$];

   task automatic model_reset();
      m_val = '0; m_dir = '0; m_pen = '0; m_pol = '0; m_od = '0; m_rd = '0;
      sync_q.delete();
      for (int s = 0; s < SYNC; s++) sync_q.push_back('0);
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         logic [W-1:0] seen;
         seen = (m_dir & m_val) | (~m_dir & sync_q[0]);
         if (bus_sel && !bus_wr) begin
            case (int'(bus_addr))
               0:  m_rd = seen;
               1:  m_rd = m_dir;
               12: m_rd = m_pen;
               13: m_rd = m_pol;
               14: m_rd = m_od;
               default: m_rd = '0;
            endcase
         end
         if (bus_sel && bus_wr) begin
            case (int'(bus_addr))
               0:  m_val = bus_wdata;
               1:  m_dir = bus_wdata;
               12: m_pen = bus_wdata;
               13: m_pol = bus_wdata;
               14: m_od  = bus_wdata;
               default: ;
            endcase
         end
         sync_q.push_back(pin_in);
         void'(sync_q.pop_front());
      end
   end

   task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [W-1:0] e_oe;
         e_oe = m_dir & (~m_od | ~m_val);
         cmp("R6 R7 R8 output enable", pad_oe, e_oe);
         cmp("R6 R7 R10 driven level", pad_out & e_oe, m_val & e_oe);
         cmp("R4 pull-up", pad_pu, ~m_dir & m_pen & ~m_pol);
         cmp("R4 pull-down", pad_pd, ~m_dir & m_pen & m_pol);
         cmp("R5 pull overlap", pad_pu & pad_pd, '0);
         cmp("R2 R3 R9 R10 read data", bus_rdata, m_rd);
      end
   end

   task automatic bus_write(int a, logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(int a);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      cmp("R1 reset oe", pad_oe, '0);
      cmp("R1 reset pull-up", pad_pu, '0);
      cmp("R1 reset pull-down", pad_pd, '0);
      cmp("R1 reset read data", bus_rdata, '0);
      rst_n = 1'b1;
      bus_read(0); bus_read(1); bus_read(14);

      // R2 write/readback of every mapped register
      bus_write(1, 8'hA5); bus_write(12, 8'h3C);
      bus_write(13, 8'h0F); bus_write(14, 8'h99);
      bus_read(1); bus_read(12); bus_read(13); bus_read(14);

      // R4 R5 pull combinations
      bus_write(1, 8'h00); bus_write(12, 8'hFF); bus_write(13, 8'hAA);
      bus_write(13, 8'h55); bus_write(12, 8'h0F);

      // R3 input levels through the synchroniser
      pin_in = 8'hC3; bus_read(0);
      bus_read(0); bus_read(0);
      pin_in = 8'h5A; @(negedge clk); bus_read(0); bus_read(0);

      // R6 push-pull, R7 open-drain
      bus_write(1, 8'hFF); bus_write(14, 8'h00);
      bus_write(0, 8'h96); bus_read(0);
      bus_write(14, 8'hF0); bus_write(0, 8'h3C); bus_write(0, 8'hC3);
      bus_read(0);

      // R8 open-drain bits on inputs
      bus_write(1, 8'h0F); bus_write(14, 8'hFF); bus_write(0, 8'hFF);
      bus_write(1, 8'h00);

      // R10 value kept while input, driven once output
      bus_write(14, 8'h00); bus_write(0, 8'h6C);
      pin_in = 8'h00; bus_read(0);
      bus_write(1, 8'hFF); bus_read(0);

      // R9 every unmapped offset
      for (int a = 0; a < 16; a++) begin
         if (a != 0 && a != 1 && a != 12 && a != 13 && a != 14) begin
            bus_write(a, 8'hE7);
            bus_read(a);
         end
      end
      bus_read(0); bus_read(1); bus_read(12); bus_read(13); bus_read(14);

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         int pick;
         @(negedge clk);
         pick = int'($urandom_range(0, 7));
         bus_sel   = ($urandom_range(0, 3) != 0);
         bus_wr    = $urandom_range(0, 1) == 1;
         bus_addr  = AW'((pick == 0) ? 0 : (pick == 1) ? 1 : (pick == 2) ? 12 :
                         (pick == 3) ? 13 : (pick == 4) ? 14 : $urandom_range(2, 11));
         bus_wdata = W'($urandom);
         if ($urandom_range(0, 2) == 0) pin_in = W'($urandom);
      end
      @(negedge clk);
      bus_sel = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule